// File: doc/BRIEF.md
# Write-Run Operation Buffer

This block packs individual byte-write requests into a compact on-chip byte memory so that a later executor can replay them against a flash device. A request that carries a full 24-bit address opens a new write record. A follow-on request that carries only a data byte extends the open record by one byte. Each record is a write opcode, a length byte, a 3-byte start address and the data bytes. The 8-bit length uses 0 to stand for 256. When an extension arrives at a record that already holds 256 bytes, a fresh record starting 256 bytes further on is opened automatically.

The caller sees how many buffer bytes are in use and gets a one-cycle error pulse for any request that cannot be taken. Rejected requests leave the buffer untouched. An init request empties the buffer. A combinational read port exposes any buffer byte to the executor.

Top module: `write_run_buf`

## Requirements
- R1: A record is stored at consecutive buffer indices as: opcode 0x00, length byte, start address low byte, middle byte, high byte, then the data bytes in arrival order.
- R2: An accepted address-carrying write (wr_byte_i) opens a new record of length 1 at index used_o and raises used_o by 6 on the next cycle.
- R3: An accepted follow-on write (wr_next_i) to an open record below 256 bytes adds 1 to that record's length byte, stores the data at index used_o, and raises used_o by 1.
- R4: A length byte of 0x00 means 256 data bytes, so a run of one address write plus 255 follow-on writes fills exactly 261 buffer bytes and leaves the length byte at 0x00.
- R5: A follow-on write to a record holding 256 bytes opens a new length-1 record whose start address is the previous start plus 256 (modulo 2^24), and raises used_o by 6.
- R6: A follow-on write with no open record is rejected: err_o is high for the cycle after the request, and used_o and the stored bytes do not change.
- R7: A request needing more bytes than DEPTH minus used_o is rejected with err_o and leaves used_o and the record state unchanged; used_o never exceeds DEPTH.
- R8: init_i sets used_o to 0 and closes the open record on the next cycle. It takes priority over a write request in the same cycle, which is dropped without an error.
- R9: wr_byte_i and wr_next_i asserted together without init_i are rejected with err_o and change nothing.
- R10: After reset, used_o is 0, err_o is 0 and no record is open.
- R11: rd_data_o shows, in the same cycle, the stored byte at index rd_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Empty the buffer |
| wr_byte_i | input | 1 | Write a byte at addr_i, opening a new record |
| wr_next_i | input | 1 | Write a byte at the next address of the open record |
| addr_i | input | 24 | Start address for wr_byte_i |
| data_i | input | 8 | Data byte for either write request |
| rd_addr_i | input | AW (10) | Buffer index to read |
| rd_data_o | output | 8 | Byte stored at rd_addr_i |
| used_o | output | UW (11) | Buffer bytes in use |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
Two collisions can happen in the same cycle. In one, init_i meets a write request; in the other, the two write kinds meet each other. The bench first builds a record. It then raises init_i together with wr_byte_i and expects used_o back at 0 with no error. A follow-on write issued afterwards must be rejected, which shows that the record was closed rather than replaced. It also raises both write strobes together and expects an error pulse with used_o and the stored bytes unchanged. The length wrap is driven as well: an extension and a new-record creation meet on the 257th byte, and the bench expects the second record's header at index 261.

// File: rtl/opbuf_pkg.sv
package opbuf_pkg;
  localparam logic [7:0] OP_WRITE  = 8'h00;
  localparam int         REC_BYTES = 6;   // op + len + 3 addr + 1 data
  localparam int         LANES     = 6;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_NEW,
    ACT_APPEND,
    ACT_REJECT
  } act_e;
endpackage

// File: rtl/opbuf_ctrl.sv
module opbuf_ctrl
  import opbuf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int UW    = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          wr_byte_i,
  input  logic          wr_next_i,
  input  logic [23:0]   addr_i,
  input  logic [7:0]    data_i,
  output logic          lane_en_o  [LANES],
  output logic [AW-1:0] lane_idx_o [LANES],
  output logic [7:0]    lane_dat_o [LANES],
  output logic [UW-1:0] used_o,
  output logic          err_o,
  output logic          open_o,
  output logic [7:0]    len_o
);
  logic [UW-1:0] used_q, room;
  logic          open_q, err_q;
  logic [7:0]    len_q;
  logic [23:0]   start_q, new_addr;
  logic [AW-1:0] hdr_q;
  act_e          act;
  logic [7:0]    hdr_bytes [LANES];

  assign room = UW'(DEPTH) - used_q;

  always_comb begin
    act      = ACT_NONE;
    new_addr = addr_i;
    if (init_i) begin
      act = ACT_NONE;
    end else if (wr_byte_i && wr_next_i) begin
      act = ACT_REJECT;
    end else if (wr_byte_i) begin
      act = (room >= UW'(REC_BYTES)) ? ACT_NEW : ACT_REJECT;
    end else if (wr_next_i) begin
      if (!open_q) begin
        act = ACT_REJECT;
      end else if (len_q == 8'd0) begin
        // record full at 256: roll over into a new record
        new_addr = start_q + 24'd256;
        act      = (room >= UW'(REC_BYTES)) ? ACT_NEW : ACT_REJECT;
      end else begin
        act = (room >= UW'(1)) ? ACT_APPEND : ACT_REJECT;
      end
    end
  end

  always_comb begin
    hdr_bytes[0] = OP_WRITE;
    hdr_bytes[1] = 8'd1;
    hdr_bytes[2] = new_addr[7:0];
    hdr_bytes[3] = new_addr[15:8];
    hdr_bytes[4] = new_addr[23:16];
    hdr_bytes[5] = data_i;
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      lane_en_o[k]  = 1'b0;
      lane_idx_o[k] = '0;
      lane_dat_o[k] = '0;
    end
    if (act == ACT_NEW) begin
      for (int k = 0; k < LANES; k++) begin
        lane_en_o[k]  = 1'b1;
        lane_idx_o[k] = used_q[AW-1:0] + AW'(k);
        lane_dat_o[k] = hdr_bytes[k];
      end
    end else if (act == ACT_APPEND) begin
      lane_en_o[0]  = 1'b1;
      lane_idx_o[0] = hdr_q + AW'(1);
      lane_dat_o[0] = len_q + 8'd1;
      lane_en_o[1]  = 1'b1;
      lane_idx_o[1] = used_q[AW-1:0];
      lane_dat_o[1] = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q  <= '0;
      open_q  <= 1'b0;
      err_q   <= 1'b0;
      len_q   <= '0;
      start_q <= '0;
      hdr_q   <= '0;
    end else begin
      err_q <= (act == ACT_REJECT);
      if (init_i) begin
        used_q <= '0;
        open_q <= 1'b0;
        len_q  <= '0;
      end else if (act == ACT_NEW) begin
        used_q  <= used_q + UW'(REC_BYTES);
        open_q  <= 1'b1;
        len_q   <= 8'd1;
        start_q <= new_addr;
        hdr_q   <= used_q[AW-1:0];
      end else if (act == ACT_APPEND) begin
        used_q <= used_q + UW'(1);
        len_q  <= len_q + 8'd1;
      end
    end
  end

  assign used_o = used_q;
  assign err_o  = err_q;
  assign open_o = open_q;
  assign len_o  = len_q;
endmodule

// File: rtl/opbuf_mem.sv
module opbuf_mem
  import opbuf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lane_en_i  [LANES],
  input  logic [AW-1:0] lane_idx_i [LANES],
  input  logic [7:0]    lane_dat_i [LANES],
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en_i[l]) mem[lane_idx_i[l]] <= lane_dat_i[l];
      end
    end
  end

  assign rd_data_o = ({1'b0, rd_addr_i} < (AW+1)'(DEPTH)) ? mem[rd_addr_i] : 8'h00;
endmodule

// File: rtl/write_run_buf.sv
module write_run_buf
  import opbuf_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int UW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          wr_byte_i,
  input  logic          wr_next_i,
  input  logic [23:0]   addr_i,
  input  logic [7:0]    data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [UW-1:0] used_o,
  output logic          err_o
);
  logic          lane_en  [LANES];
  logic [AW-1:0] lane_idx [LANES];
  logic [7:0]    lane_dat [LANES];
  logic          open_w;
  logic [7:0]    len_w;

  opbuf_ctrl #(.DEPTH(DEPTH), .AW(AW), .UW(UW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_i),
    .wr_byte_i  (wr_byte_i),
    .wr_next_i  (wr_next_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .lane_en_o  (lane_en),
    .lane_idx_o (lane_idx),
    .lane_dat_o (lane_dat),
    .used_o     (used_o),
    .err_o      (err_o),
    .open_o     (open_w),
    .len_o      (len_w)
  );

  opbuf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lane_en_i  (lane_en),
    .lane_idx_i (lane_idx),
    .lane_dat_i (lane_dat),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/opbuf_chk.sv
module opbuf_chk #(
  parameter int DEPTH = 1024,
  parameter int UW    = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          init_i,
  input logic          wr_byte_i,
  input logic          wr_next_i,
  input logic [UW-1:0] used_i,
  input logic          err_i,
  input logic          open_i,
  input logic [7:0]    len_i
);
  assert_used_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_i <= UW'(DEPTH));

  assert_init_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (used_i == '0 && !err_i && !open_i));

  assert_next_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_next_i && !wr_byte_i && !init_i && !open_i) |=> (err_i && $stable(used_i)));

  assert_new_six_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_byte_i && !wr_next_i && !init_i && (used_i <= UW'(DEPTH - 6)))
      |=> (used_i == $past(used_i) + UW'(6) && len_i == 8'd1 && !err_i));

  assert_append_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_next_i && !wr_byte_i && !init_i && open_i && len_i != 8'd0 && used_i < UW'(DEPTH))
      |=> (used_i == $past(used_i) + UW'(1) && len_i == $past(len_i) + 8'd1));

  assert_both_reject_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_byte_i && wr_next_i && !init_i) |=> (err_i && $stable(used_i)));
endmodule

bind write_run_buf opbuf_chk #(.DEPTH(DEPTH), .UW(UW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .init_i    (init_i),
  .wr_byte_i (wr_byte_i),
  .wr_next_i (wr_next_i),
  .used_i    (used_o),
  .err_i     (err_o),
  .open_i    (open_w),
  .len_i     (len_w)
);

// File: tb/sim_write_run_buf.sv
`timescale 1ns/1ps
module sim_write_run_buf;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);
  localparam int UW    = $clog2(DEPTH + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          init_i = 1'b0, wr_byte_i = 1'b0, wr_next_i = 1'b0;
  logic [23:0]   addr_i = '0;
  logic [7:0]    data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0]    rd_data_o;
  logic [UW-1:0] used_o;
  logic          err_o;

  int total = 0;
  int bad   = 0;

  always #10 clk_i = ~clk_i;

  write_run_buf #(.DEPTH(DEPTH)) u0 (
    .clk_i, .rst_ni, .init_i, .wr_byte_i, .wr_next_i, .addr_i, .data_i,
    .rd_addr_i, .rd_data_o, .used_o, .err_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive one request for one cycle; returns err_o seen after the edge
  task automatic req(input logic ini, input logic wb, input logic wn,
                     input int a, input int d, output int e);
    @(negedge clk_i);
    init_i = ini; wr_byte_i = wb; wr_next_i = wn;
    addr_i = a[23:0]; data_i = d[7:0];
    @(negedge clk_i);
    init_i = 1'b0; wr_byte_i = 1'b0; wr_next_i = 1'b0;
    e = int'(err_o);
  endtask

  task automatic rd(input int a, output int v);
    rd_addr_i = a[AW-1:0];
    #1;
    v = int'(rd_data_o);
  endtask

  task automatic t_reset;
    chk("R10 used after reset", int'(used_o), 0);
    chk("R10 err after reset", int'(err_o), 0);
  endtask

  task automatic t_single;
    int e, v;
    req(1'b0, 1'b1, 1'b0, 24'h123456, 8'hA5, e);
    chk("R2 err", e, 0);
    chk("R2 used", int'(used_o), 6);
    rd(0, v); chk("R1 opcode", v, 8'h00);
    rd(1, v); chk("R1 len", v, 8'h01);
    rd(2, v); chk("R1 addr lo", v, 8'h56);
    rd(3, v); chk("R1 addr mid", v, 8'h34);
    rd(4, v); chk("R1 addr hi", v, 8'h12);
    rd(5, v); chk("R11 data", v, 8'hA5);
    req(1'b0, 1'b0, 1'b1, 0, 8'h3C, e);
    req(1'b0, 1'b0, 1'b1, 0, 8'h4D, e);
    chk("R3 err", e, 0);
    chk("R3 used", int'(used_o), 8);
    rd(1, v); chk("R3 len", v, 8'h03);
    rd(6, v); chk("R3 data 1", v, 8'h3C);
    rd(7, v); chk("R3 data 2", v, 8'h4D);
  endtask

  task automatic t_collide;
    int e, v;
    req(1'b0, 1'b1, 1'b1, 24'h000111, 8'h99, e);
    chk("R9 err", e, 1);
    chk("R9 used", int'(used_o), 8);
    rd(8, v); chk("R9 no write", v, 8'h00);
    req(1'b1, 1'b1, 1'b0, 24'h000222, 8'h88, e);
    chk("R8 err", e, 0);
    chk("R8 used", int'(used_o), 0);
    req(1'b0, 1'b0, 1'b1, 0, 8'h11, e);
    chk("R6 err", e, 1);
    chk("R6 used", int'(used_o), 0);
    rd(0, v); chk("R6 buffer kept", v, 8'h00);
    rd(5, v); chk("R6 byte kept", v, 8'hA5);
  endtask

  task automatic t_wrap;
    int e, v;
    req(1'b1, 1'b0, 1'b0, 0, 0, e);
    req(1'b0, 1'b1, 1'b0, 24'h00FF00, 8'h00, e);
    for (int k = 1; k < 256; k++) req(1'b0, 1'b0, 1'b1, 0, k, e);
    chk("R4 used", int'(used_o), 261);
    rd(1, v);   chk("R4 len zero", v, 8'h00);
    rd(260, v); chk("R4 last data", v, 8'hFF);
    req(1'b0, 1'b0, 1'b1, 0, 8'h77, e);
    chk("R5 err", e, 0);
    chk("R5 used", int'(used_o), 267);
    rd(261, v); chk("R5 opcode", v, 8'h00);
    rd(262, v); chk("R5 len", v, 8'h01);
    rd(263, v); chk("R5 addr lo", v, 8'h00);
    rd(264, v); chk("R5 addr mid", v, 8'h00);
    rd(265, v); chk("R5 addr hi", v, 8'h01);
    rd(266, v); chk("R5 data", v, 8'h77);
    rd(1, v);   chk("R5 old len", v, 8'h00);
  endtask

  task automatic t_full;
    int e, v;
    req(1'b1, 1'b0, 1'b0, 0, 0, e);
    for (int k = 0; k < 170; k++) req(1'b0, 1'b1, 1'b0, k * 16, k, e);
    chk("R7 used 1020", int'(used_o), 1020);
    req(1'b0, 1'b1, 1'b0, 24'hABCDEF, 8'h5A, e);
    chk("R7 new rejected", e, 1);
    chk("R7 used kept", int'(used_o), 1020);
    rd(1020, v); chk("R7 no write", v, 8'h00);
    for (int k = 0; k < 4; k++) req(1'b0, 1'b0, 1'b1, 0, 8'hE0 + k, e);
    chk("R7 tail err", e, 0);
    chk("R7 used full", int'(used_o), 1024);
    rd(1015, v); chk("R7 last len", v, 8'h05);
    rd(1023, v); chk("R7 last data", v, 8'hE3);
    req(1'b0, 1'b0, 1'b1, 0, 8'h66, e);
    chk("R7 append rejected", e, 1);
    chk("R7 used capped", int'(used_o), 1024);
    rd(1015, v); chk("R7 len kept", v, 8'h05);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_collide();
    t_wrap();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule